// File: doc/BRIEF.md
# Shadowed Per-Channel Configuration Register Bank

This block holds the byte-wide configuration state of a four-channel data converter. A serial-bus decoder in front of it presents an 8-bit address, 8-bit write data and a write strobe; the bank answers reads through a combinational read-data bus. Channel-specific settings (power mode and duty-cycle stabilizer enable) live in two copies per channel: a master copy that host writes land in, and a live copy that drives the datapath. An index register decides which channel masters a write reaches. Only an explicit transfer command moves all masters into the live copies, on a single clock edge, so several channels can be reprogrammed and then switched over at the same time.

Global registers sit alongside the channel copies. They are a port-configuration byte with mirrored bit-order and soft-reset controls, two read-only identification bytes, and the transfer command byte. A soft reset returns every writable register, masters and live copies included, to its default in one cycle.

Top module: `cfg_shadow_bank`

## Requirements
- R1: After reset, address 0x00 reads 0x18, 0x05 reads 0x0F, 0x08 reads 0x00, 0x09 reads 0x01 and 0xFF reads 0x00. All live power modes are 0, all live stabilizer enables are 1, and `lsb_first` is 0.
- R2: Address 0x01 always reads 0x04. Writes to it change nothing.
- R3: Address 0x02 always reads 0x40 (grade code 3'b100 in bits [6:4], other bits 0). Writes to it change nothing.
- R4: Address 0x05 stores write data bits [5:0] and reads them back with bits [7:6] as 0. Bits 0 to 3 enable data channels 0 to 3. Bit 4 enables the frame-clock channel and bit 5 the data-clock channel.
- R5: A write to 0x08 (bits [2:0]) or 0x09 (bit 0) updates the master copy only for data channels whose index bit is set at the time of the write. Live outputs do not change because of that write.
- R6: A write to 0xFF with bit 0 set copies every channel master into its live copy on that clock edge, and the live output buses show the new values after that edge. A write to 0xFF with bit 0 clear changes nothing. 0xFF always reads 0x00.
- R7: A read of 0x08 or 0x09 returns the live value of the lowest-numbered data channel whose index bit is set. It returns 0x00 when no data-channel index bit is set.
- R8: A write to 0x00 without a soft-reset bit sets `lsb_first` to bit 6 OR bit 1 of the data. 0x00 then reads back with that value mirrored in bits 6 and 1 and with bits 4 and 3 as 1 (0x5A when set).
- R9: A write to 0x00 with bit 5 or bit 2 set returns, on that edge, the index register, `lsb_first`, all masters and all live copies to their defaults. The soft-reset bits read back as 0.
- R10: Reads of unmapped addresses return 0x00. Writes to unmapped addresses change no register and no output.
- R11: Address 0x08 keeps only bits [2:0] (0 run, 1 full power-down, 2 standby, 3 reset) and reads bits [7:3] as 0. Address 0x09 keeps only bit 0 and reads bits [7:1] as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| addr | input | 8 | Register address for writes and reads |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| lsb_first | output | 1 | Serial bit-order select, LSB first when 1 |
| live_pmode | output | 12 | Live power mode, 3 bits per channel, channel 0 in [2:0] |
| live_dcs_en | output | 4 | Live duty-cycle stabilizer enable, one bit per channel |

## Verification
The bench stages master writes into a subset of channels and then checks that the live buses stay unchanged. A design that copies writes straight into the live registers fails there, as does one that transfers on a 0xFF write with bit 0 clear. Read steering is probed with index patterns where the lowest enabled channel is not channel 0, with no data channel set, and with only clock-channel bits set. A wrong priority encoder returns another channel's value or stale data. Soft reset is fired through each of its two mirrored bits while masters hold pending values, and a transfer follows it. A design that leaves masters untouched would then push stale settings live. Read-only and unmapped writes are followed by readbacks and bus checks that would reveal any stray decode.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
   localparam int BYTE_W = 8;

   localparam logic [BYTE_W-1:0] ADDR_PORT   = 8'h00;
   localparam logic [BYTE_W-1:0] ADDR_ID     = 8'h01;
   localparam logic [BYTE_W-1:0] ADDR_GRADE  = 8'h02;
   localparam logic [BYTE_W-1:0] ADDR_INDEX  = 8'h05;
   localparam logic [BYTE_W-1:0] ADDR_PMODE  = 8'h08;
   localparam logic [BYTE_W-1:0] ADDR_CLKCTL = 8'h09;
   localparam logic [BYTE_W-1:0] ADDR_XFER   = 8'hFF;

   // bit positions inside the port-configuration byte (mirrored pairs)
   localparam int PORT_LSB_HI  = 6;
   localparam int PORT_LSB_LO  = 1;
   localparam int PORT_SRST_HI = 5;
   localparam int PORT_SRST_LO = 2;
   localparam int PORT_ONE_HI  = 4;
   localparam int PORT_ONE_LO  = 3;

   localparam int XFER_BIT = 0;
   localparam int CLK_CH_N = 2;   // frame-clock and data-clock channel bits

   typedef enum logic [2:0] {
      PWR_RUN   = 3'd0,
      PWR_OFF   = 3'd1,
      PWR_STBY  = 3'd2,
      PWR_RESET = 3'd3
   } pwr_mode_e;
endpackage

// File: rtl/cfg_chan_slot.sv
module cfg_chan_slot
   import cfg_bank_pkg::*;
#(
   parameter int   PMODE_W = 3,
   parameter logic DCS_RST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_rst,
   input  logic               wr_pmode,
   input  logic               wr_dcs,
   input  logic               xfer,
   input  logic [BYTE_W-1:0]  wdata,
   output logic [PMODE_W-1:0] live_pmode,
   output logic               live_dcs
);
   localparam logic [PMODE_W-1:0] PMODE_RST = PMODE_W'(PWR_RUN);

   generate
      if (PMODE_W < 1 || PMODE_W > BYTE_W) begin : g_bad_pmode_w
         $error("cfg_chan_slot: PMODE_W must lie in 1..BYTE_W");
      end
   endgenerate

   logic [PMODE_W-1:0] mst_pmode;
   logic               mst_dcs;

   // master copy: written through the index-gated strobes
   always_ff @(posedge clk) begin
      if (!rst_n || soft_rst) begin
         mst_pmode <= PMODE_RST;
         mst_dcs   <= DCS_RST;
      end else begin
         if (wr_pmode) mst_pmode <= wdata[PMODE_W-1:0];
         if (wr_dcs)   mst_dcs   <= wdata[0];
      end
   end

   // live copy: changes only on transfer or soft reset
   always_ff @(posedge clk) begin
      if (!rst_n || soft_rst) begin
         live_pmode <= PMODE_RST;
         live_dcs   <= DCS_RST;
      end else if (xfer) begin
         live_pmode <= mst_pmode;
         live_dcs   <= mst_dcs;
      end
   end

   a_r6_live_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer && !soft_rst) |=> ($stable(live_pmode) && $stable(live_dcs)));

   a_r6_live_takes_master: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && !soft_rst) |=> (live_pmode == $past(mst_pmode) && live_dcs == $past(mst_dcs)));

   a_r5_master_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_pmode && !wr_dcs && !soft_rst) |=> ($stable(mst_pmode) && $stable(mst_dcs)));

   a_r9_slot_defaults: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (live_pmode == PMODE_RST && live_dcs == DCS_RST
                    && mst_pmode == PMODE_RST && mst_dcs == DCS_RST));
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
   import cfg_bank_pkg::*;
#(
   parameter int NUM_CH = 4,
   localparam int IDX_W = NUM_CH + CLK_CH_N
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic              soft_rst,
   output logic              xfer,
   output logic              lsb_first,
   output logic [IDX_W-1:0]  index,
   output logic [NUM_CH-1:0] wr_pmode,
   output logic [NUM_CH-1:0] wr_dcs
);
   localparam logic [IDX_W-1:0] IDX_RST = {{CLK_CH_N{1'b0}}, {NUM_CH{1'b1}}};

   generate
      if (NUM_CH < 1 || IDX_W > BYTE_W) begin : g_bad_num_ch
         $error("cfg_global_regs: NUM_CH plus clock channels must fit in a byte");
      end
   endgenerate

   logic wr_port, wr_index, wr_pm_any, wr_dcs_any;

   always_comb begin
      wr_port    = wr_en && (addr == ADDR_PORT);
      wr_index   = wr_en && (addr == ADDR_INDEX);
      wr_pm_any  = wr_en && (addr == ADDR_PMODE);
      wr_dcs_any = wr_en && (addr == ADDR_CLKCTL);
      soft_rst   = wr_port && (wdata[PORT_SRST_HI] || wdata[PORT_SRST_LO]);
      xfer       = wr_en && (addr == ADDR_XFER) && wdata[XFER_BIT];
      wr_pmode   = {NUM_CH{wr_pm_any}}  & index[NUM_CH-1:0];
      wr_dcs     = {NUM_CH{wr_dcs_any}} & index[NUM_CH-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n || soft_rst) begin
         index     <= IDX_RST;
         lsb_first <= 1'b0;
      end else begin
         if (wr_index) index <= wdata[IDX_W-1:0];
         if (wr_port)  lsb_first <= wdata[PORT_LSB_HI] || wdata[PORT_LSB_LO];
      end
   end

   a_r9_global_defaults: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (index == IDX_RST && !lsb_first));

   a_r4_index_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_index && !soft_rst) |=> $stable(index));

   a_r6_xfer_not_with_srst: assert property (@(posedge clk) disable iff (!rst_n)
      !(xfer && soft_rst));
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
   import cfg_bank_pkg::*;
#(
   parameter int               NUM_CH   = 4,
   parameter int               PMODE_W  = 3,
   parameter logic [BYTE_W-1:0] CHIP_ID = 8'h04,
   parameter logic [2:0]       GRADE_ID = 3'b100,
   localparam int IDX_W = NUM_CH + CLK_CH_N
) (
   input  logic [BYTE_W-1:0]         addr,
   input  logic [IDX_W-1:0]          index,
   input  logic                      lsb_first,
   input  logic [NUM_CH*PMODE_W-1:0] live_pmode,
   input  logic [NUM_CH-1:0]         live_dcs,
   output logic [BYTE_W-1:0]         rdata
);
   logic [PMODE_W-1:0] pm_arr [NUM_CH];
   logic [NUM_CH-1:0]  first_sel;

   // unpack the flat bus and find the lowest enabled data channel
   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         assign pm_arr[c] = live_pmode[c*PMODE_W +: PMODE_W];
         if (c == 0) begin : g_lead
            assign first_sel[c] = index[0];
         end else begin : g_rest
            assign first_sel[c] = index[c] && !(|index[c-1:0]);
         end
      end
   endgenerate

   logic [PMODE_W-1:0] sel_pm;
   logic               sel_dcs;

   always_comb begin
      sel_pm  = '0;
      sel_dcs = 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
         sel_pm  = sel_pm  | ({PMODE_W{first_sel[c]}} & pm_arr[c]);
         sel_dcs = sel_dcs | (first_sel[c] & live_dcs[c]);
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_PORT: begin
            rdata[PORT_LSB_HI] = lsb_first;
            rdata[PORT_LSB_LO] = lsb_first;
            rdata[PORT_ONE_HI] = 1'b1;
            rdata[PORT_ONE_LO] = 1'b1;
         end
         ADDR_ID:     rdata = CHIP_ID;
         ADDR_GRADE:  rdata[6:4] = GRADE_ID;
         ADDR_INDEX:  rdata[IDX_W-1:0] = index;
         ADDR_PMODE:  rdata[PMODE_W-1:0] = sel_pm;
         ADDR_CLKCTL: rdata[0] = sel_dcs;
         default:     rdata = '0;
      endcase
   end

   always_comb begin
      a_r7_single_source: assert ($onehot0(first_sel));
      if (index[NUM_CH-1:0] == '0 && (addr == ADDR_PMODE || addr == ADDR_CLKCTL))
         a_r7_none_reads_zero: assert (rdata == '0);
   end
endmodule

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank
   import cfg_bank_pkg::*;
#(
   parameter int                NUM_CH   = 4,
   parameter int                PMODE_W  = 3,
   parameter logic              DCS_RST  = 1'b1,
   parameter logic [BYTE_W-1:0] CHIP_ID  = 8'h04,
   parameter logic [2:0]        GRADE_ID = 3'b100
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [7:0]                addr,
   input  logic [7:0]                wdata,
   output logic [7:0]                rdata,
   output logic                      lsb_first,
   output logic [NUM_CH*PMODE_W-1:0] live_pmode,
   output logic [NUM_CH-1:0]         live_dcs_en
);
   localparam int IDX_W = NUM_CH + CLK_CH_N;

   logic              soft_rst, xfer;
   logic [IDX_W-1:0]  index;
   logic [NUM_CH-1:0] wr_pmode, wr_dcs;

   cfg_global_regs #(.NUM_CH(NUM_CH)) u_glob (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (addr),
      .wdata    (wdata),
      .soft_rst (soft_rst),
      .xfer     (xfer),
      .lsb_first(lsb_first),
      .index    (index),
      .wr_pmode (wr_pmode),
      .wr_dcs   (wr_dcs)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
         cfg_chan_slot #(.PMODE_W(PMODE_W), .DCS_RST(DCS_RST)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .soft_rst  (soft_rst),
            .wr_pmode  (wr_pmode[c]),
            .wr_dcs    (wr_dcs[c]),
            .xfer      (xfer),
            .wdata     (wdata),
            .live_pmode(live_pmode[c*PMODE_W +: PMODE_W]),
            .live_dcs  (live_dcs_en[c])
         );
      end
   endgenerate

   cfg_read_mux #(
      .NUM_CH  (NUM_CH),
      .PMODE_W (PMODE_W),
      .CHIP_ID (CHIP_ID),
      .GRADE_ID(GRADE_ID)
   ) u_rmux (
      .addr      (addr),
      .index     (index),
      .lsb_first (lsb_first),
      .live_pmode(live_pmode),
      .live_dcs  (live_dcs_en),
      .rdata     (rdata)
   );

   a_r10_unmapped_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr != ADDR_PORT && addr != ADDR_INDEX && addr != ADDR_PMODE
       && addr != ADDR_CLKCTL && addr != ADDR_XFER)
      |=> ($stable(live_pmode) && $stable(live_dcs_en) && $stable(lsb_first) && $stable(index)));
endmodule

// File: tb/cfg_shadow_bank_tb_top.sv
`timescale 1ns/1ps
module cfg_shadow_bank_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [7:0]  wdata = 8'h00;
   logic [7:0]  rdata;
   logic        lsb_first;
   logic [11:0] live_pmode;
   logic [3:0]  live_dcs_en;

   always #2 clk = ~clk;   // 250 MHz

   cfg_shadow_bank dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .lsb_first(lsb_first), .live_pmode(live_pmode),
      .live_dcs_en(live_dcs_en)
   );

   typedef struct {
      bit          is_bus;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb[$];

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // reference model built from the requirements
   bit [2:0] m_mst [4];
   bit [2:0] m_live[4];
   bit       m_mdcs[4];
   bit       m_ldcs[4];
   bit [5:0] m_idx;
   bit       m_lsb;

   function automatic void model_reset();
      for (int c = 0; c < 4; c++) begin
         m_mst[c] = 3'd0; m_live[c] = 3'd0; m_mdcs[c] = 1'b1; m_ldcs[c] = 1'b1;
      end
      m_idx = 6'h0F;
      m_lsb = 1'b0;
   endfunction

   function automatic logic [7:0] exp_read(input logic [7:0] a);
      logic [7:0] v;
      v = 8'h00;
      case (a)
         8'h00: v = {1'b0, m_lsb, 1'b0, 1'b1, 1'b1, 1'b0, m_lsb, 1'b0};
         8'h01: v = 8'h04;
         8'h02: v = 8'h40;
         8'h05: v = {2'b00, m_idx};
         8'h08: for (int c = 3; c >= 0; c--) if (m_idx[c]) v = {5'b0, m_live[c]};
         8'h09: for (int c = 3; c >= 0; c--) if (m_idx[c]) v = {7'b0, m_ldcs[c]};
         default: v = 8'h00;
      endcase
      return v;
   endfunction

   function automatic logic [31:0] exp_bus();
      logic [31:0] v;
      v = '0;
      for (int c = 0; c < 4; c++) begin
         v[c*3 +: 3] = m_live[c];
         v[12 + c]   = m_ldcs[c];
      end
      v[16] = m_lsb;
      return v;
   endfunction

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      case (a)
         8'h00: if (d[5] || d[2]) model_reset(); else m_lsb = d[6] | d[1];
         8'h05: m_idx = d[5:0];
         8'h08: for (int c = 0; c < 4; c++) if (m_idx[c]) m_mst[c] = d[2:0];
         8'h09: for (int c = 0; c < 4; c++) if (m_idx[c]) m_mdcs[c] = d[0];
         8'hFF: if (d[0]) for (int c = 0; c < 4; c++) begin
                   m_live[c] = m_mst[c]; m_ldcs[c] = m_mdcs[c];
                end
         default: ;
      endcase
      #1 wr_en = 1'b0;
   endtask

   task automatic chk_rd(input logic [7:0] a, input string tag);
      item_t it;
      @(posedge clk); #1;
      wr_en = 1'b0; addr = a;
      it.is_bus = 1'b0; it.exp = {24'h0, exp_read(a)};
      it.tag = $sformatf("%s read 0x%02h", tag, a);
      sb.push_back(it);
   endtask

   task automatic chk_bus(input string tag);
      item_t it;
      @(posedge clk); #1;
      wr_en = 1'b0;
      it.is_bus = 1'b1; it.exp = exp_bus(); it.tag = {tag, " live bus"};
      sb.push_back(it);
   endtask

   // monitor: compares one queued item per cycle, away from the active edge
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = sb.pop_front();
         act = it.is_bus ? {15'h0, lsb_first, live_dcs_en, live_pmode} : {24'h0, rdata};
         n_chk++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
         end
      end
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // reset state
      chk_rd(8'h00, "R1"); chk_rd(8'h05, "R1"); chk_rd(8'h08, "R1");
      chk_rd(8'h09, "R1"); chk_rd(8'hFF, "R1"); chk_bus("R1");
      chk_rd(8'h01, "R2"); chk_rd(8'h02, "R3"); chk_rd(8'h33, "R10");

      // read-only registers ignore writes
      wr(8'h01, 8'hFF); chk_rd(8'h01, "R2"); chk_bus("R2");
      wr(8'h02, 8'h00); chk_rd(8'h02, "R3"); chk_bus("R3");

      // index register
      wr(8'h05, 8'hFF); chk_rd(8'h05, "R4");
      wr(8'h05, 8'h02); chk_rd(8'h05, "R4");

      // staged write to channel 1 only, not yet live
      wr(8'h08, 8'hFA); wr(8'h09, 8'h00);
      chk_bus("R5"); chk_rd(8'h08, "R5"); chk_rd(8'h09, "R5");

      // transfer
      wr(8'hFF, 8'h01);
      chk_bus("R6"); chk_rd(8'hFF, "R6");
      chk_rd(8'h08, "R11"); chk_rd(8'h09, "R11");

      // channels 2 and 3, then lowest-enabled steering
      wr(8'h05, 8'h0C); wr(8'h08, 8'h03); wr(8'h09, 8'h01);
      chk_bus("R5");
      wr(8'hFF, 8'hFF); chk_bus("R6");
      chk_rd(8'h08, "R7"); chk_rd(8'h09, "R7");
      wr(8'h05, 8'h0E); chk_rd(8'h08, "R7"); chk_rd(8'h09, "R7");
      wr(8'h05, 8'h08); chk_rd(8'h08, "R7");
      wr(8'h05, 8'h00); chk_rd(8'h08, "R7"); chk_rd(8'h09, "R7");
      wr(8'h05, 8'h30); chk_rd(8'h08, "R7"); chk_rd(8'h05, "R4");

      // transfer with bit 0 clear does nothing
      wr(8'h05, 8'h01); wr(8'h08, 8'h02);
      wr(8'hFF, 8'hFE); chk_bus("R6"); chk_rd(8'h08, "R6");

      // unmapped write
      wr(8'h40, 8'hFF); chk_bus("R10"); chk_rd(8'h05, "R10");
      chk_rd(8'h00, "R10"); chk_rd(8'h40, "R10");

      // bit order, both mirrored bits
      wr(8'h00, 8'h02); chk_rd(8'h00, "R8"); chk_bus("R8");
      wr(8'h00, 8'h00); chk_rd(8'h00, "R8");
      wr(8'h00, 8'h40); chk_rd(8'h00, "R8"); chk_bus("R8");

      // soft reset through bit 2 with pending masters
      wr(8'h05, 8'h0F); wr(8'h08, 8'h01);
      wr(8'h00, 8'h04);
      chk_rd(8'h00, "R9"); chk_rd(8'h05, "R9"); chk_bus("R9");
      wr(8'hFF, 8'h01); chk_bus("R9");

      // soft reset through bit 5
      wr(8'h09, 8'h00); wr(8'hFF, 8'h01); wr(8'h00, 8'h42);
      chk_bus("R9");
      wr(8'h00, 8'h20);
      chk_rd(8'h00, "R9"); chk_rd(8'h09, "R9"); chk_bus("R9");

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(4 * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule